// File: doc/BRIEF.md
# In-Place 64-Point Radix-2 FFT Engine with Prefix Stripping

This block is the transform stage of an OFDM receiver. After a start request it collects one OFDM symbol from a stream of 16-bit I/Q samples. A symbol is 80 complex samples. The 16 prefix samples at its head are dropped and the remaining 64 are written into two 64-word data memories, one for the real parts and one for the imaginary parts. The engine then runs a decimation-in-frequency radix-2 schedule in place over those memories. The schedule has six passes of 32 butterflies, and one butterfly issues per clock.

Each butterfly writes its sum half straight back to memory. The difference half is held in a register for one cycle, and in the next cycle it is multiplied by a Q1.15 twiddle factor taken from separate cosine and negative-sine tables. Every pass halves its outputs, so the stored result is the DFT divided by 64. The result stays in bit-reversed order. A single-cycle done pulse marks the end of a run, and the result can then be read word by word through a registered read port.

Top module: `ofdm_fft_core`

## Requirements
- R1: While reset is low and in the first cycle after it, busy and done are both 0. A reset in the middle of a run abandons the run and returns the engine to idle.
- R2: A start seen while idle sets busy in the next cycle and arms collection. Samples offered while idle, and in the start cycle itself, are not stored. Of the valid samples that follow, the first 16 are discarded and the next 64 are stored at addresses 0 to 63 in arrival order.
- R3: When the run ends, address a holds X[k]/64 with k = a bit-reversed over 6 bits and X[k] = sum over n of x[n]·e^(−j2πnk/64). Real and imaginary parts are each within 3 LSB of this value, as two's complement numbers.
- R4: done rises in the 198th clock after the edge that accepts the 64th kept sample. This is six passes of 32 butterfly cycles, each pass followed by one drain cycle.
- R5: done stays high for exactly one cycle, and busy is 0 in that cycle.
- R6: start is ignored while busy, during collection and during computation. The collection position, the result and the done timing are all unaffected.
- R7: The prefix counter restarts for every symbol, so each run drops the first 16 valid samples of its own symbol.
- R8: A cycle with in_valid low neither advances the sample position nor writes memory.
- R9: rd_addr is sampled on a clock edge, and rd_re/rd_im show that word from the next cycle on. Between edges the outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to collect and transform one symbol |
| in_valid | input | 1 | Qualifies in_re/in_im in this cycle |
| in_re | input | 16 | Sample real part, two's complement |
| in_im | input | 16 | Sample imaginary part, two's complement |
| rd_addr | input | 6 | Result word to read (bit-reversed bin order) |
| busy | output | 1 | High while collecting or computing |
| done | output | 1 | One-cycle pulse at the end of a transform |
| rd_re | output | 16 | Real part of the addressed word, registered |
| rd_im | output | 16 | Imaginary part of the addressed word, registered |

## Verification
The hardest case to reach from the ports is a start request that lands while the engine is busy. It has to land in a cycle where it could do real damage: a gap cycle in the middle of collection, and the middle of the butterfly schedule. The bench forces these by pulsing start inside a deliberate in_valid gap and again about 50 cycles into computation. It then confirms that both the spectrum and the 198-cycle done timing come out unchanged. Junk samples fed while idle and in the start cycle, recognisable garbage in the prefix slots, and single-bin tones at both positive and negative frequencies together expose any slip in the sample position and any sign error in the twiddle factors.

// File: rtl/fft_pkg.sv
// Shared definitions for the 64-point FFT engine.
// Assumes: transform size fixed at 2**FFT_LOG2 = 64, twiddles in Q1.15.
package fft_pkg;
    localparam int FFT_LOG2 = 6;
    localparam int TW_W     = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_CALC = 2'd2
    } fft_state_e;

    // Quarter-wave cosine table: round(32767*cos(k*pi/32)), k = 0..16.
    function automatic int qcos(input int k);
        case (k)
            0:  return 32767;
            1:  return 32609;
            2:  return 32137;
            3:  return 31356;
            4:  return 30273;
            5:  return 28898;
            6:  return 27245;
            7:  return 25329;
            8:  return 23170;
            9:  return 20787;
            10: return 18204;
            11: return 15446;
            12: return 12539;
            13: return 9512;
            14: return 6393;
            15: return 3212;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/fft_symbol_loader.sv
// Symbol loader: while armed, counts valid input samples, drops the
// first CP_LEN of them and produces write strobes for the next 2**LOG2_N.
// Assumes: armed stays high until last has been signalled.
module fft_symbol_loader #(
    parameter int LOG2_N = 6,
    parameter int CP_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              in_valid,
    output logic              we,
    output logic [LOG2_N-1:0] waddr,
    output logic              last
);
    localparam int NPTS    = 1 << LOG2_N;
    localparam int SYM_LEN = CP_LEN + NPTS;
    localparam int SC_W    = $clog2(SYM_LEN + 1);

    logic [SC_W-1:0] pos_q;

    // Position within the symbol; cleared whenever collection is not armed.
    always_ff @(posedge clk) begin
        if (!rst_n)           pos_q <= '0;
        else if (!armed)      pos_q <= '0;
        else if (in_valid)    pos_q <= pos_q + SC_W'(1);
    end

    // Store strobe and address once the prefix has passed.
    always_comb begin
        we    = armed && in_valid && (pos_q >= SC_W'(CP_LEN));
        waddr = LOG2_N'(pos_q - SC_W'(CP_LEN));
        last  = armed && in_valid && (pos_q == SC_W'(SYM_LEN - 1));
    end

    // R7
    pos_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> (pos_q == '0));

    // R8
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !in_valid) |=> $stable(pos_q));
endmodule

// File: rtl/fft_twiddle_rom.sv
// Twiddle lookup: one part (real = cos, imaginary = -sin) of
// exp(-j*2*pi*idx/64), built from a quarter-wave cosine table.
// Assumes: idx < 32, output in Q1.15.
module fft_twiddle_rom
    import fft_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter bit IMAG  = 1'b0
) (
    input  logic [IDX_W-1:0]        idx,
    output logic signed [TW_W-1:0]  val
);
    localparam int QUART = 1 << (IDX_W - 1);
    localparam int HALF  = 1 << IDX_W;

    if (IMAG) begin : g_im
        // -sin(k*pi/32) folded onto the cosine quarter.
        always_comb begin
            int k;
            k = int'(idx);
            if (k <= QUART) val = TW_W'(-qcos(QUART - k));
            else            val = TW_W'(-qcos(k - QUART));
        end
    end else begin : g_re
        // cos(k*pi/32), negated beyond the quarter point.
        always_comb begin
            int k;
            k = int'(idx);
            if (k <= QUART) val = TW_W'(qcos(k));
            else            val = TW_W'(-qcos(HALF - k));
        end
    end
endmodule

// File: rtl/fft_sequencer.sv
// Run sequencer: idle/load/compute states, pass and butterfly counters,
// in-place address generation for the radix-2 DIF schedule, done pulse.
// Assumes: one butterfly per clock, one drain cycle after each pass so the
// delayed lower-half write lands before the next pass reads.
module fft_sequencer
    import fft_pkg::*;
#(
    parameter int LOG2_N = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              load_last,
    output fft_state_e        state_o,
    output logic              issue,
    output logic [LOG2_N-1:0] top_addr,
    output logic [LOG2_N-1:0] bot_addr,
    output logic [LOG2_N-2:0] tw_idx,
    output logic              done
);
    localparam int NBF      = 1 << (LOG2_N - 1);
    localparam int STG_W    = $clog2(LOG2_N + 1);
    localparam int LAST_STG = LOG2_N - 1;
    localparam int DRAIN    = NBF;

    fft_state_e        state_q;
    logic [STG_W-1:0]  stage_q;
    logic [LOG2_N-1:0] cnt_q;
    logic              done_q;
    logic [LOG2_N-1:0] span_w, within_w, group_w, top_w;

    // Pass state machine and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stage_q <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) state_q <= ST_LOAD;
                ST_LOAD: if (load_last) begin
                    state_q <= ST_CALC;
                    stage_q <= '0;
                    cnt_q   <= '0;
                end
                ST_CALC: begin
                    if (cnt_q == LOG2_N'(DRAIN)) begin
                        cnt_q <= '0;
                        if (stage_q == STG_W'(LAST_STG)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            stage_q <= stage_q + STG_W'(1);
                        end
                    end else begin
                        cnt_q <= cnt_q + LOG2_N'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Butterfly operand addresses and twiddle index for this pass.
    always_comb begin
        span_w   = LOG2_N'(NBF) >> stage_q;
        within_w = cnt_q & (span_w - LOG2_N'(1));
        group_w  = cnt_q >> (STG_W'(LOG2_N - 1) - stage_q);
        top_w    = (group_w << (STG_W'(LOG2_N) - stage_q)) | within_w;
        top_addr = top_w;
        bot_addr = top_w | span_w;
        tw_idx   = (LOG2_N-1)'(within_w << stage_q);
        issue    = (state_q == ST_CALC) && (cnt_q < LOG2_N'(NBF));
    end

    assign state_o = state_q;
    assign done    = done_q;

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R4
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(state_q == ST_CALC && stage_q == STG_W'(LAST_STG)
                         && cnt_q == LOG2_N'(DRAIN)));

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ((state_q == ST_LOAD && !load_last) ||
                   (state_q == ST_CALC && cnt_q != LOG2_N'(DRAIN))))
        |=> (state_q == $past(state_q)));
endmodule

// File: rtl/fft_butterfly.sv
// Radix-2 DIF butterfly: the sum half is returned combinationally (halved),
// the difference is registered together with its twiddle and destination,
// then multiplied as a complex product, halved and saturated one cycle later.
// Assumes: twiddle in Q1.15, operands are two's complement.
module fft_butterfly #(
    parameter int DW  = 16,
    parameter int TWW = 16,
    parameter int AW  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue,
    input  logic signed [DW-1:0]  x_re,
    input  logic signed [DW-1:0]  x_im,
    input  logic signed [DW-1:0]  y_re,
    input  logic signed [DW-1:0]  y_im,
    input  logic signed [TWW-1:0] tw_re,
    input  logic signed [TWW-1:0] tw_im,
    input  logic [AW-1:0]         bot_addr,
    output logic signed [DW-1:0]  a_re,
    output logic signed [DW-1:0]  a_im,
    output logic                  b_we,
    output logic [AW-1:0]         b_addr,
    output logic signed [DW-1:0]  b_re,
    output logic signed [DW-1:0]  b_im
);
    localparam int SW   = DW + 1;
    localparam int PW   = SW + TWW;
    localparam int MW   = PW + 1;
    localparam int SHR  = TWW;            // Q1.15 product scale plus pass halving
    localparam logic signed [MW-1:0] SMAX = MW'((1 << (DW - 1)) - 1);
    localparam logic signed [MW-1:0] SMIN = -SMAX - MW'(1);

    logic signed [SW-1:0]  sum_re, sum_im, dif_re, dif_im;
    logic signed [SW-1:0]  d_re_q, d_im_q;
    logic signed [TWW-1:0] w_re_q, w_im_q;
    logic                  bv_q;
    logic [AW-1:0]         ba_q;
    logic signed [PW-1:0]  p_rr, p_ii, p_ri, p_ir;
    logic signed [MW-1:0]  m_re, m_im, s_re, s_im;

    // Widened sum and difference of the two operands.
    always_comb begin
        sum_re = SW'(x_re) + SW'(y_re);
        sum_im = SW'(x_im) + SW'(y_im);
        dif_re = SW'(x_re) - SW'(y_re);
        dif_im = SW'(x_im) - SW'(y_im);
        a_re   = DW'(sum_re >>> 1);
        a_im   = DW'(sum_im >>> 1);
    end

    // Difference register: aligns the lower half with its twiddle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_re_q <= '0;
            d_im_q <= '0;
            w_re_q <= '0;
            w_im_q <= '0;
            bv_q   <= 1'b0;
            ba_q   <= '0;
        end else begin
            bv_q <= issue;
            if (issue) begin
                d_re_q <= dif_re;
                d_im_q <= dif_im;
                w_re_q <= tw_re;
                w_im_q <= tw_im;
                ba_q   <= bot_addr;
            end
        end
    end

    // Complex twiddle product, halving and saturation.
    always_comb begin
        p_rr = PW'(d_re_q) * PW'(w_re_q);
        p_ii = PW'(d_im_q) * PW'(w_im_q);
        p_ri = PW'(d_re_q) * PW'(w_im_q);
        p_ir = PW'(d_im_q) * PW'(w_re_q);
        m_re = MW'(p_rr) - MW'(p_ii);
        m_im = MW'(p_ri) + MW'(p_ir);
        s_re = m_re >>> SHR;
        s_im = m_im >>> SHR;
        if (s_re > SMAX)      b_re = DW'(SMAX);
        else if (s_re < SMIN) b_re = DW'(SMIN);
        else                  b_re = DW'(s_re);
        if (s_im > SMAX)      b_im = DW'(SMAX);
        else if (s_im < SMIN) b_im = DW'(SMIN);
        else                  b_im = DW'(s_im);
    end

    assign b_we   = bv_q;
    assign b_addr = ba_q;
endmodule

// File: rtl/ofdm_fft_core.sv
// Top of the 64-point in-place FFT engine: symbol loader, sequencer,
// twiddle tables, butterfly and the split real/imaginary data memories.
// Assumes: results are read only while idle; data memories carry no reset.
module ofdm_fft_core
    import fft_pkg::*;
#(
    parameter int DW     = 16,
    parameter int CP_LEN = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                in_valid,
    input  logic [DW-1:0]       in_re,
    input  logic [DW-1:0]       in_im,
    input  logic [FFT_LOG2-1:0] rd_addr,
    output logic                busy,
    output logic                done,
    output logic [DW-1:0]       rd_re,
    output logic [DW-1:0]       rd_im
);
    localparam int NPTS  = 1 << FFT_LOG2;
    localparam int TIX_W = FFT_LOG2 - 1;

    fft_state_e          state;
    logic                ld_we, ld_last, issue, b_we;
    logic [FFT_LOG2-1:0] ld_addr, top_addr, bot_addr, b_addr;
    logic [TIX_W-1:0]    tw_idx;
    logic signed [TW_W-1:0] tw_val [2];
    logic signed [DW-1:0] x_re, x_im, y_re, y_im, a_re, a_im, b_re, b_im;
    logic [DW-1:0]       mem_re [NPTS];
    logic [DW-1:0]       mem_im [NPTS];
    logic [DW-1:0]       rd_re_q, rd_im_q;

    fft_symbol_loader #(.LOG2_N(FFT_LOG2), .CP_LEN(CP_LEN)) u_loader (
        .clk(clk), .rst_n(rst_n), .armed(state == ST_LOAD),
        .in_valid(in_valid), .we(ld_we), .waddr(ld_addr), .last(ld_last)
    );

    fft_sequencer #(.LOG2_N(FFT_LOG2)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .load_last(ld_last),
        .state_o(state), .issue(issue), .top_addr(top_addr),
        .bot_addr(bot_addr), .tw_idx(tw_idx), .done(done)
    );

    // Index 0 holds the cosine table, index 1 the negative-sine table.
    for (genvar p = 0; p < 2; p++) begin : g_tw
        fft_twiddle_rom #(.IDX_W(TIX_W), .IMAG(p == 1)) u_rom (
            .idx(tw_idx), .val(tw_val[p])
        );
    end

    // Operand fetch from both memories.
    always_comb begin
        x_re = $signed(mem_re[top_addr]);
        x_im = $signed(mem_im[top_addr]);
        y_re = $signed(mem_re[bot_addr]);
        y_im = $signed(mem_im[bot_addr]);
    end

    fft_butterfly #(.DW(DW), .TWW(TW_W), .AW(FFT_LOG2)) u_bfly (
        .clk(clk), .rst_n(rst_n), .issue(issue),
        .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
        .tw_re(tw_val[0]), .tw_im(tw_val[1]), .bot_addr(bot_addr),
        .a_re(a_re), .a_im(a_im), .b_we(b_we), .b_addr(b_addr),
        .b_re(b_re), .b_im(b_im)
    );

    // Memory writes: loader samples, butterfly upper half, delayed lower half.
    always_ff @(posedge clk) begin
        if (ld_we) begin
            mem_re[ld_addr] <= in_re;
            mem_im[ld_addr] <= in_im;
        end
        if (issue) begin
            mem_re[top_addr] <= a_re;
            mem_im[top_addr] <= a_im;
        end
        if (b_we) begin
            mem_re[b_addr] <= b_re;
            mem_im[b_addr] <= b_im;
        end
    end

    // Registered result read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_re_q <= '0;
            rd_im_q <= '0;
        end else begin
            rd_re_q <= mem_re[rd_addr];
            rd_im_q <= mem_im[rd_addr];
        end
    end

    assign rd_re = rd_re_q;
    assign rd_im = rd_im_q;
    assign busy  = (state != ST_IDLE);

    // R3
    half_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && b_we) |-> (b_addr != top_addr));

    // R2
    load_only_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |-> (busy && !issue && !b_we));
endmodule

// File: tb/ofdm_fft_core_test.sv
`timescale 1ns/1ps
module ofdm_fft_core_test;
    localparam int NP   = 64;
    localparam int CP   = 16;
    localparam int LAT  = 198;
    localparam int TOL  = 3;
    localparam real PI  = 3.14159265358979;
    localparam int NVEC = 6;
    // kind: 0 impulse at bin, 1 complex tone, 2 real cosine, 3 ramp
    localparam int V_KIND [NVEC] = '{0, 1, 1, 2, 0, 3};
    localparam int V_BIN  [NVEC] = '{0, 5, 63, 3, 1, 0};
    localparam int V_AMP  [NVEC] = '{6400, 4000, 4000, 3000, 5000, 2000};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
    logic [15:0] in_re = '0, in_im = '0;
    logic [5:0]  rd_addr = '0;
    logic        busy, done;
    logic [15:0] rd_re, rd_im;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int xr [NP];
    int xi [NP];

    ofdm_fft_core uut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im), .rd_addr(rd_addr),
        .busy(busy), .done(done), .rd_re(rd_re), .rd_im(rd_im)
    );

    always #2.5 clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    function automatic int absi(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int bitrev(input int a);
        int r = 0;
        for (int b = 0; b < 6; b++) if (a[b]) r |= 1 << (5 - b);
        return r;
    endfunction

    function automatic void make_symbol(input int kind, input int bin, input int amp);
        for (int n = 0; n < NP; n++) begin
            real ang;
            ang = 2.0 * PI * real'(bin * n) / real'(NP);
            case (kind)
                0: begin xr[n] = (n == bin) ? amp : 0; xi[n] = 0; end
                1: begin xr[n] = rnd(amp * $cos(ang)); xi[n] = rnd(amp * $sin(ang)); end
                2: begin xr[n] = rnd(amp * $cos(ang)); xi[n] = 0; end
                default: begin xr[n] = amp * (n - 32) / 32; xi[n] = (n % 7) * 300 - 900; end
            endcase
        end
    endfunction

    // Feed one symbol after a start; optional gaps and start pokes while busy.
    task automatic run_symbol(input bit gaps, input bit poke, input string tag);
        int lat;
        bit got;
        // R2: junk offered while idle must not be stored
        for (int j = 0; j < 5; j++) begin
            in_valid = 1'b1; in_re = 16'h7000; in_im = 16'h7000;
            @(posedge clk); @(negedge clk);
        end
        start = 1'b1;  // sample in the start cycle is junk too
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        for (int i = 0; i < CP + NP; i++) begin
            if (gaps && (i % 5 == 2)) begin
                in_valid = 1'b0; in_re = 16'h1234; in_im = 16'h4321;
                start = poke && (i == 42);  // R6 start during collection
                @(posedge clk); @(negedge clk);
                start = 1'b0;
            end
            in_valid = 1'b1;
            if (i < CP) begin in_re = 16'd20000; in_im = 16'(-20000); end
            else begin in_re = 16'(xr[i-CP]); in_im = 16'(xi[i-CP]); end
            @(posedge clk); @(negedge clk);
        end
        in_valid = 1'b0;
        lat = 0; got = 0;
        while (!got && lat < 400) begin
            start = poke && (lat == 50);  // R6 start during computation
            @(posedge clk); lat++;
            @(negedge clk); start = 1'b0;
            if (done) got = 1;
        end
        chk(lat == LAT, {"R4 done latency ", tag}, lat, LAT);
        chk(busy == 1'b0, "R5 busy low with done", busy, 0);
        @(posedge clk); @(negedge clk);
        chk(done == 1'b0, "R5 done one cycle", done, 0);
        chk(busy == 1'b0, "R6 stays idle after pokes", busy, 0);
    endtask

    // Compare every word against the scaled DFT at the bit-reversed bin.
    task automatic check_results(input string tag);
        for (int a = 0; a < NP; a++) begin
            int k, er, ei, ar, ai;
            real sr, si;
            k = bitrev(a); sr = 0.0; si = 0.0;
            for (int n = 0; n < NP; n++) begin
                real ang;
                ang = -2.0 * PI * real'(n * k) / real'(NP);
                sr += xr[n] * $cos(ang) - xi[n] * $sin(ang);
                si += xr[n] * $sin(ang) + xi[n] * $cos(ang);
            end
            er = rnd(sr / NP); ei = rnd(si / NP);
            rd_addr = 6'(a);
            @(posedge clk); @(negedge clk);
            ar = int'($signed(rd_re)); ai = int'($signed(rd_im));
            chk(absi(ar - er) <= TOL, {tag, " real"}, ar, er);
            chk(absi(ai - ei) <= TOL, {tag, " imag"}, ai, ei);
        end
    endtask

    initial begin
        int hold;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 in reset", {busy, done}, 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 after reset", {busy, done}, 0);

        // Vector table: R3 transform, R8 gaps, R6 pokes, R7 repeated symbols
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            bit gaps, poke;
            gaps = (v % 2 == 1);
            poke = (v == 2) || (v == 5);
            if (poke)        tag = "R6 start ignored";
            else if (v == 0) tag = "R2 R3 transform";
            else if (gaps)   tag = "R8 gapped input";
            else             tag = "R7 next symbol";
            make_symbol(V_KIND[v], V_BIN[v], V_AMP[v]);
            run_symbol(gaps, poke, tag);
            check_results(tag);
        end

        // R9: read port is registered
        rd_addr = 6'd0;
        @(posedge clk); @(negedge clk);
        hold = int'(rd_re);
        rd_addr = 6'd40;
        #1;
        chk(int'(rd_re) == hold, "R9 output holds between edges", int'(rd_re), hold);

        // R1: reset during collection abandons the run
        @(negedge clk);
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 30; i++) begin
            in_valid = 1'b1; in_re = 16'd999; in_im = 16'd999;
            @(posedge clk); @(negedge clk);
        end
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 reset mid-run", {busy, done}, 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        make_symbol(1, 9, 3500);
        run_symbol(1'b0, 1'b0, "R1 run after reset");
        check_results("R1 R7 run after reset");

        summary();
    end
endmodule